// File: doc/BRIEF.md
# Tuner Control Register Slave over I2C

This block is a two-wire serial slave that keeps the control state of a frequency-synthesized tuner. A host addresses it with a 7-bit device address and writes a short byte stream. The first two data bytes carry a 15-bit synthesizer divider word. The following bytes carry the loop and output controls: a reference divider select, a charge pump current, a test mode, a general-purpose output bit and an enable for the buffered reference output. If the host reads instead, the block returns a status byte with a power-on flag and the synthesizer lock state.

The divider word is double-buffered so that tuning moves in one step. Bytes first land in a shadow register. The word presented to the synthesizer changes only when the low byte completes, or when a STOP ends the transfer. A power-on or brown-out pulse returns every control to its default and raises the power-on flag. The flag stays up until a host has read it in a transfer that ends with STOP.

Both bus lines are sampled through two-stage synchronizers, and SDA is driven open-drain through an enable. Inside the block, received bytes travel from the bus engine to the register file as a valid-only stream. The register file takes a byte on any cycle, so that stream has no ready and no back-pressure. The bus protocol itself offers no way to stall a write byte, and clock stretching is not used.

Top module: `tuner_ctl_i2c`

## Requirements
- R1: After reset the divider word is 0, the reference divider select, charge pump current, test mode and general-purpose bit are 0, the reference-output enable is 1, and SDA is not driven.
- R2: The slave acknowledges an address byte only when its upper 7 bits equal DEV_ADDR (default 7'h61); bit 0 of that byte is 1 for read and 0 for write. A transfer to any other address gets no acknowledge and changes no output.
- R3: In a write, data byte 0 bits 6:0 become divider bits 14:8 (bit 7 is ignored) and data byte 1 becomes bits 7:0. The divider output takes the full new word once byte 1 completes.
- R4: A STOP commits the shadow word; a write that ends after byte 0 gives an output of the new bits 14:8 joined with the earlier bits 7:0.
- R5: A STOP that arrives partway through a data byte discards the partial byte: no register changes from it.
- R6: Data byte 2 sets charge pump current from bits 7:6 and test mode from bits 5:3. Data byte 3 sets reference divider select from bits 4:0, the general-purpose bit from bit 5 (1 drives the pin, 0 leaves it undriven) and the reference-output enable from bit 6. Further data bytes are acknowledged and ignored.
- R7: In a read, each byte sent is the status byte: bit 1 is the power-on flag, bit 2 is the synchronized lock input, and the other bits are 0. The same byte repeats for as long as the host acknowledges.
- R8: The power-on flag clears only when a read transfer to this slave ends with STOP. A STOP after a write, or a repeated START after a read, leaves it set.
- R9: A pulse on por_pulse_i restores every R1 default, including divider word 0, and sets the power-on flag on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low |
| lock_i | input | 1 | Synthesizer phase-lock indication |
| por_pulse_i | input | 1 | Power-on or supply-drop event, synchronous |
| freq_word | output | FREQ_W | Active synthesizer divider word |
| ref_sel | output | 5 | Reference divider select |
| cp_cur | output | 2 | Charge pump current code |
| test_mode | output | 3 | Test mode code |
| gp_drive | output | 1 | General-purpose port: 1 drives on, 0 high impedance |
| refout_en | output | 1 | Buffered reference output enable |

## Verification
On every cycle the assertions check four things. The divider word moves only at a byte commit, a STOP or a power-on event. The control fields move only on a written byte or a power-on event. The power-on flag rises only after a power-on event and falls only after a STOP that ends a read. A power-on event always leaves the default state behind it. Only the bench scenarios can show the rest: the exact byte-to-field mapping, the address filter, the value the host reads, and what a partial byte, a STOP after the high byte or a repeated START does to the registers.

// File: rtl/tuner_ctl_pkg.sv
package tuner_ctl_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } bus_state_e;

  typedef struct packed {
    logic [4:0] ref_sel;
    logic       gp_drive;
    logic       refout_en;
    logic [1:0] cp_cur;
    logic [2:0] test_mode;
  } ctrl_t;

  localparam ctrl_t CTRL_DEFAULT = '{ref_sel: 5'd0, gp_drive: 1'b0, refout_en: 1'b1,
                                     cp_cur: 2'd0, test_mode: 3'd0};

endpackage

// File: rtl/tuner_sync.sv
module tuner_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/tuner_i2c_core.sv
module tuner_i2c_core
  import tuner_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] status_byte,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              txn_start,
  output logic              stop_evt,
  output logic              stop_rd
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  bus_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx_sr, tx_sr;
  logic              scl_d, sda_d;
  logic              addr_ph, rd_mode, addressed, mack;
  logic              scl_rise, scl_fall, start_det, stop_det;

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  // open-drain: pull low for acknowledge, or for a zero data bit
  assign sda_oe = (state == ST_ACK) | ((state == ST_TX) & ~tx_sr[BYTE_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      addr_ph   <= 1'b0;
      rd_mode   <= 1'b0;
      addressed <= 1'b0;
      mack      <= 1'b0;
      wr_valid  <= 1'b0;
      wr_data   <= '0;
      txn_start <= 1'b0;
      stop_evt  <= 1'b0;
      stop_rd   <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      txn_start <= 1'b0;
      stop_evt  <= 1'b0;
      stop_rd   <= 1'b0;
      if (abort) begin
        state     <= ST_IDLE;
        addressed <= 1'b0;
        rd_mode   <= 1'b0;
      end else if (start_det) begin
        state     <= ST_RX;
        cnt       <= '0;
        addr_ph   <= 1'b1;
        addressed <= 1'b0;
        rd_mode   <= 1'b0;
        txn_start <= 1'b1;
      end else if (stop_det) begin
        state     <= ST_IDLE;
        stop_evt  <= 1'b1;
        stop_rd   <= addressed & rd_mode;
        addressed <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && cnt != CNT_FULL) begin
              rx_sr <= {rx_sr[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_FULL) begin
              cnt <= '0;
              if (addr_ph) begin
                if (rx_sr[BYTE_W-1:1] == DEV_ADDR) begin
                  addressed <= 1'b1;
                  rd_mode   <= rx_sr[0];
                  state     <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                wr_valid <= 1'b1;
                wr_data  <= rx_sr;
                state    <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              addr_ph <= 1'b0;
              cnt     <= '0;
              if (rd_mode) begin
                tx_sr <= status_byte;
                state <= ST_TX;
              end else begin
                state <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == CNT_LAST) begin
                cnt   <= '0;
                state <= ST_TXACK;
              end else begin
                tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
                cnt   <= cnt + 1'b1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                tx_sr <= status_byte;
                state <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tuner_regs.sv
module tuner_regs
  import tuner_ctl_pkg::*;
#(
  parameter int FREQ_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_evt,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              txn_start,
  input  logic              stop_evt,
  input  logic              stop_rd,
  input  logic              lock_s,
  output logic [FREQ_W-1:0] freq_word,
  output ctrl_t             ctrl,
  output logic              por_flag,
  output logic [BYTE_W-1:0] status_byte
);
  localparam int HI_W = FREQ_W - BYTE_W;
  localparam int IDX_W = 3;
  localparam logic [IDX_W-1:0] IDX_HI   = 3'd0;
  localparam logic [IDX_W-1:0] IDX_LO   = 3'd1;
  localparam logic [IDX_W-1:0] IDX_LOOP = 3'd2;
  localparam logic [IDX_W-1:0] IDX_OUT  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_SAT  = 3'd4;

  logic [FREQ_W-1:0] shadow;
  logic [IDX_W-1:0]  idx;

  assign status_byte = {5'b00000, lock_s, por_flag, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow    <= '0;
      freq_word <= '0;
      ctrl      <= CTRL_DEFAULT;
      por_flag  <= 1'b1;
      idx       <= '0;
    end else if (por_evt) begin
      shadow    <= '0;
      freq_word <= '0;
      ctrl      <= CTRL_DEFAULT;
      por_flag  <= 1'b1;
      idx       <= '0;
    end else begin
      if (txn_start) idx <= '0;
      if (wr_valid) begin
        case (idx)
          IDX_HI: shadow[FREQ_W-1:BYTE_W] <= wr_data[HI_W-1:0];
          IDX_LO: begin
            shadow[BYTE_W-1:0] <= wr_data;
            freq_word          <= {shadow[FREQ_W-1:BYTE_W], wr_data};
          end
          IDX_LOOP: begin
            ctrl.cp_cur    <= wr_data[7:6];
            ctrl.test_mode <= wr_data[5:3];
          end
          IDX_OUT: begin
            ctrl.ref_sel   <= wr_data[4:0];
            ctrl.gp_drive  <= wr_data[5];
            ctrl.refout_en <= wr_data[6];
          end
          default: ;
        endcase
        if (idx != IDX_SAT) idx <= idx + 1'b1;
      end
      if (stop_evt) begin
        freq_word <= shadow;
        if (stop_rd) por_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tuner_ctl_i2c.sv
module tuner_ctl_i2c
  import tuner_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h61,
  parameter int         SYNC_STAGES = 2,
  parameter int         FREQ_W      = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              lock_i,
  input  logic              por_pulse_i,
  output logic [FREQ_W-1:0] freq_word,
  output logic [4:0]        ref_sel,
  output logic [1:0]        cp_cur,
  output logic [2:0]        test_mode,
  output logic              gp_drive,
  output logic              refout_en
);
  localparam int N_SYNC = 3;
  localparam logic [N_SYNC-1:0] SYNC_RST = 3'b011;

  logic [N_SYNC-1:0] sync_in, sync_out;
  logic              scl_s, sda_s, lock_s;
  logic              wr_valid, txn_start, stop_evt, stop_rd, por_flag;
  logic [BYTE_W-1:0] wr_data, status_byte;
  ctrl_t             ctrl;

  assign sync_in = {lock_i, sda_i, scl_i};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    tuner_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[g])) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sync_in[g]), .q(sync_out[g])
    );
  end

  assign scl_s  = sync_out[0];
  assign sda_s  = sync_out[1];
  assign lock_s = sync_out[2];

  tuner_i2c_core #(.DEV_ADDR(DEV_ADDR)) u_core (
    .clk(clk), .rst_n(rst_n), .abort(por_pulse_i),
    .scl_s(scl_s), .sda_s(sda_s), .status_byte(status_byte),
    .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_data(wr_data),
    .txn_start(txn_start), .stop_evt(stop_evt), .stop_rd(stop_rd)
  );

  tuner_regs #(.FREQ_W(FREQ_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .por_evt(por_pulse_i),
    .wr_valid(wr_valid), .wr_data(wr_data), .txn_start(txn_start),
    .stop_evt(stop_evt), .stop_rd(stop_rd), .lock_s(lock_s),
    .freq_word(freq_word), .ctrl(ctrl), .por_flag(por_flag),
    .status_byte(status_byte)
  );

  assign ref_sel   = ctrl.ref_sel;
  assign cp_cur    = ctrl.cp_cur;
  assign test_mode = ctrl.test_mode;
  assign gp_drive  = ctrl.gp_drive;
  assign refout_en = ctrl.refout_en;
endmodule

// File: rtl/tuner_ctl_chk.sv
module tuner_ctl_chk #(
  parameter int FREQ_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_pulse_i,
  input logic [FREQ_W-1:0] freq_word,
  input logic [4:0]        ref_sel,
  input logic [1:0]        cp_cur,
  input logic [2:0]        test_mode,
  input logic              gp_drive,
  input logic              refout_en,
  input logic              wr_valid,
  input logic              stop_evt,
  input logic              stop_rd,
  input logic              por_flag
);
  // R9
  por_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_pulse_i |=> (freq_word == '0 && ref_sel == 5'd0 && cp_cur == 2'd0 &&
                     test_mode == 3'd0 && !gp_drive && refout_en && por_flag));

  // R3
  freq_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_word) |-> $past(wr_valid || stop_evt || por_pulse_i));

  // R6
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ref_sel, cp_cur, test_mode, gp_drive, refout_en}) |->
      $past(wr_valid || por_pulse_i));

  // R8
  por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_flag) |-> $past(stop_evt && stop_rd));

  // R9
  por_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_flag) |-> $past(por_pulse_i));
endmodule

bind tuner_ctl_i2c tuner_ctl_chk #(.FREQ_W(FREQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .por_pulse_i(por_pulse_i), .freq_word(freq_word),
  .ref_sel(ref_sel), .cp_cur(cp_cur), .test_mode(test_mode), .gp_drive(gp_drive),
  .refout_en(refout_en), .wr_valid(wr_valid), .stop_evt(stop_evt),
  .stop_rd(stop_rd), .por_flag(por_flag)
);

// File: tb/tuner_ctl_i2c_tb.sv
`timescale 1ns/1ps
module tuner_ctl_i2c_tb;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h61;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, scl, sda_m, lock_i, por_pulse;
  logic sda_oe, sda_bus;
  logic [14:0] freq_word;
  logic [4:0]  ref_sel;
  logic [1:0]  cp_cur;
  logic [2:0]  test_mode;
  logic        gp_drive, refout_en;

  assign sda_bus = sda_m & ~sda_oe;

  tuner_ctl_i2c u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .lock_i(lock_i), .por_pulse_i(por_pulse), .freq_word(freq_word),
    .ref_sel(ref_sel), .cp_cur(cp_cur), .test_mode(test_mode),
    .gp_drive(gp_drive), .refout_en(refout_en)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sbq[$];
  event  chk_ev;
  int    checks = 0;
  int    errors = 0;
  logic [7:0] rd_last;
  logic       ack_last;

  function automatic logic [31:0] ctrl_pack(logic [4:0] rs, logic gp, logic re,
                                            logic [1:0] cp, logic [2:0] tm);
    return {20'd0, rs, gp, re, cp, tm};
  endfunction

  function automatic logic [31:0] actual(int k);
    case (k)
      0: return {17'd0, freq_word};
      1: return ctrl_pack(ref_sel, gp_drive, refout_en, cp_cur, test_mode);
      2: return {24'd0, rd_last};
      3: return {31'd0, ack_last};
      default: return {31'd0, sda_oe};
    endcase
  endfunction

  // monitor: pops expected items and compares them with what the design shows
  initial begin
    forever begin
      @(chk_ev);
      while (sbq.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sbq.pop_front();
        act = actual(it.kind);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind %0d actual %0h expected %0h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_val(int k, logic [31:0] e, string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    sbq.push_back(it);
    ->chk_ev;
    tick(1);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(logic b);
    sda_m = b;  tick(Q);
    scl = 1'b1; tick(2 * Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic write_byte(logic [7:0] d);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    ack_last = ~sda_bus;
    tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic read_byte(logic host_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      rd_last[i] = sda_bus;
      tick(Q);
      scl = 1'b0;
    end
    send_bit(~host_ack);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; lock_i = 1'b0; por_pulse = 1'b0;
    rd_last = '0; ack_last = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1 reset state
    expect_val(0, 32'h0, "R1 freq");
    expect_val(1, ctrl_pack(5'd0, 1'b0, 1'b1, 2'd0, 3'd0), "R1 ctrl");
    expect_val(4, 32'h0, "R1 sda_oe");

    // R2 foreign address: no ack, nothing changes
    i2c_start();
    write_byte({7'h22, 1'b0});
    expect_val(3, 32'h0, "R2 foreign nack");
    write_byte(8'h12);
    i2c_stop(); tick(Q);
    expect_val(0, 32'h0, "R2 freq untouched");

    // R3, R6 full write
    i2c_start();
    write_byte({DEV, 1'b0});
    expect_val(3, 32'h1, "R2 own ack");
    write_byte(8'h9A);
    write_byte(8'h55);
    expect_val(0, 32'h1A55, "R3 commit after low byte");
    write_byte(8'hAF);
    write_byte(8'hB3);
    write_byte(8'hFF);
    expect_val(3, 32'h1, "R6 extra byte acked");
    i2c_stop(); tick(Q);
    expect_val(0, 32'h1A55, "R6 freq unchanged by extra");
    expect_val(1, ctrl_pack(5'h13, 1'b1, 1'b0, 2'b10, 3'b101), "R6 ctrl fields");

    // R7/R8 read: POR still set after write STOP, cleared by read STOP
    i2c_start();
    write_byte({DEV, 1'b1});
    read_byte(1'b0);
    expect_val(2, 32'h02, "R8 por kept after write stop");
    i2c_stop(); tick(Q);
    i2c_start();
    write_byte({DEV, 1'b1});
    read_byte(1'b0);
    expect_val(2, 32'h00, "R8 por cleared by read stop");
    i2c_stop(); tick(Q);

    lock_i = 1'b1; tick(Q);
    i2c_start();
    write_byte({DEV, 1'b1});
    read_byte(1'b1);
    expect_val(2, 32'h04, "R7 lock status");
    read_byte(1'b0);
    expect_val(2, 32'h04, "R7 repeated status");
    i2c_stop(); tick(Q);

    // R9 power-on pulse
    por_pulse = 1'b1; tick(1);
    por_pulse = 1'b0; tick(2);
    expect_val(0, 32'h0, "R9 freq cleared");
    expect_val(1, ctrl_pack(5'd0, 1'b0, 1'b1, 2'd0, 3'd0), "R9 ctrl defaults");

    // R8 repeated START after read keeps POR; R4 STOP after high byte
    i2c_start();
    write_byte({DEV, 1'b1});
    read_byte(1'b0);
    expect_val(2, 32'h06, "R7 por and lock");
    i2c_start();
    write_byte({DEV, 1'b0});
    write_byte(8'h12);
    expect_val(0, 32'h0, "R4 no commit before stop");
    i2c_stop(); tick(Q);
    expect_val(0, 32'h1200, "R4 stop commits high byte");
    i2c_start();
    write_byte({DEV, 1'b1});
    read_byte(1'b0);
    expect_val(2, 32'h06, "R8 por kept after repeated start");
    i2c_stop(); tick(Q);

    // R5 STOP mid byte
    i2c_start();
    write_byte({DEV, 1'b0});
    write_byte(8'h05);
    write_byte(8'h66);
    expect_val(0, 32'h0566, "R3 second word");
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    i2c_stop(); tick(Q);
    expect_val(0, 32'h0566, "R5 freq after partial");
    expect_val(1, ctrl_pack(5'd0, 1'b0, 1'b1, 2'd0, 3'd0), "R5 ctrl after partial");
    expect_val(4, 32'h0, "R5 bus released");

    tick(4);
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d items", sbq.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule